// File: doc/BRIEF.md
# SIR Start Flag Sequencer

This block produces the run of opening flag bytes that a slow-rate infrared framer sends ahead of a frame's payload. A start request begins a sequence. The flag count in force at that moment fixes how many flag bytes are sent. A stored pattern-select bit fixes the value of every flag byte except the last one. The last flag byte is always 0xC0.

The flag bytes leave one at a time over a valid/ready byte handshake. When the downstream side has taken the closing 0xC0 byte, the block raises a single-cycle done pulse. The data path uses that pulse to follow with the first payload byte, so no filler byte sits between the last flag and the data. Byte stuffing, CRC, closing flags and line serialization are handled elsewhere.

Top module: `sir_bof_seq`

## Requirements
- R1: When the flag count is 1, exactly one byte, 0xC0, is emitted, whatever the stored select bit is.
- R2: When the flag count n is greater than 1, exactly n bytes are emitted. The first n-1 bytes carry the leading pattern and byte n is 0xC0.
- R3: The leading pattern is 0xFF when the stored select bit is 0 and 0xC0 when it is 1. The bit is written by pulsing `cfg_we` with the value on `cfg_sel`.
- R4: After reset the stored select bit is 1, so a multi-flag sequence started with no configuration write has all bytes equal to 0xC0.
- R5: A flag count of 0 behaves exactly as a count of 1.
- R6: The flag count and the select bit are captured when a start is accepted. Changing either one during a sequence does not alter that sequence.
- R7: A byte is consumed only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_byte` does not change.
- R8: `done` is high for exactly one cycle, the cycle right after the handshake of the closing 0xC0 byte. `out_valid` is low in that cycle.
- R9: A start request seen while `out_valid` is high is ignored. It neither restarts nor extends the sequence, and it does not queue a later one.
- R10: After reset `out_valid` and `done` are low. A start accepted while idle makes `out_valid` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the pattern-select bit |
| cfg_sel | input | 1 | Select value to store (0: 0xFF leading, 1: 0xC0 leading) |
| start_req | input | 1 | Request to begin a flag sequence |
| flag_count | input | CNT_W (6) | Number of flags; 0 is taken as 1 |
| out_ready | input | 1 | Downstream can take a byte |
| out_valid | output | 1 | A flag byte is offered |
| out_byte | output | 8 | Offered flag byte |
| done | output | 1 | One-cycle pulse after the closing flag is taken |

## Verification
The assertions assume that the downstream side may hold `out_ready` low for any number of cycles. They also assume that `start_req`, `flag_count` and the configuration inputs may change at any cycle, including during a sequence. They do not assume any fairness of `out_ready`. The stimulus drives every input on the falling clock edge. It exercises both a ready that is always high and a ready that alternates low and high. It also pulses start and configuration writes in the middle of a sequence, so every assumed input freedom is used while the outputs stay within the handshake rules.

// File: rtl/sir_bof_pkg.sv
package sir_bof_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] flag_byte_t;
  localparam flag_byte_t FLAG_CLOSE = 8'hC0;
  localparam flag_byte_t FLAG_FILL  = 8'hFF;

  function automatic flag_byte_t lead_pattern(input logic sel);
    return sel ? FLAG_CLOSE : FLAG_FILL;
  endfunction
endpackage

// File: rtl/sir_bof_cfg.sv
module sir_bof_cfg (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic sel_in,
  output logic sel_q
);
  always_ff @(posedge clk) begin
    if (rst)     sel_q <= 1'b1;
    else if (we) sel_q <= sel_in;
  end
endmodule

// File: rtl/sir_bof_count.sv
module sir_bof_count #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last_now,
  output logic             next_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (step && remain != '0)
      remain <= remain - ONE;
  end

  // flag currently offered is the closing one
  assign last_now  = (remain == ONE);
  // flag to be offered after this edge is the closing one
  assign next_last = load ? (load_val == ONE) : (remain == TWO);
endmodule

// File: rtl/sir_bof_emit.sv
module sir_bof_emit
  import sir_bof_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       hs,
  input  logic       last_now,
  input  logic       next_last,
  input  logic       sel_now,
  output logic       out_valid,
  output flag_byte_t out_byte,
  output logic       done
);
  logic sel_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      done      <= 1'b0;
      sel_lat   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (accept) begin
        sel_lat   <= sel_now;
        out_valid <= 1'b1;
        out_byte  <= next_last ? FLAG_CLOSE : lead_pattern(sel_now);
      end else if (hs) begin
        if (last_now) begin
          out_valid <= 1'b0;
          done      <= 1'b1;
        end else begin
          out_byte <= next_last ? FLAG_CLOSE : lead_pattern(sel_lat);
        end
      end
    end
  end
endmodule

// File: rtl/sir_bof_seq.sv
module sir_bof_seq
  import sir_bof_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic             start_req,
  input  logic [CNT_W-1:0] flag_count,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             done
);
  logic             sel_q;
  logic             accept;
  logic             hs;
  logic             last_now;
  logic             next_last;
  logic [CNT_W-1:0] eff_count;

  assign accept    = start_req && !out_valid;
  assign hs        = out_valid && out_ready;
  assign eff_count = (flag_count == '0) ? CNT_W'(1) : flag_count;

  sir_bof_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel_in(cfg_sel), .sel_q(sel_q)
  );

  sir_bof_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(accept), .load_val(eff_count),
    .step(hs), .last_now(last_now), .next_last(next_last)
  );

  sir_bof_emit u_emit (
    .clk(clk), .rst(rst), .accept(accept), .hs(hs),
    .last_now(last_now), .next_last(next_last), .sel_now(sel_q),
    .out_valid(out_valid), .out_byte(out_byte), .done(done)
  );
endmodule

// File: rtl/sir_bof_chk.sv
module sir_bof_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start_req,
  input logic [CNT_W-1:0] flag_count,
  input logic             out_ready,
  input logic             out_valid,
  input logic [7:0]       out_byte,
  input logic             done
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_after_close_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && $past(out_valid && out_ready && out_byte == 8'hC0)));

  // R1
  single_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start_req && !out_valid && flag_count <= CNT_W'(1)) |=>
      (out_valid && out_byte == 8'hC0));

  // R3
  flag_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_byte == 8'hC0 || out_byte == 8'hFF));

  // R10
  start_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (start_req && !out_valid) |=> out_valid);
endmodule

bind sir_bof_seq sir_bof_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .flag_count(flag_count),
  .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte), .done(done)
);

// File: tb/sir_bof_seq_bench.sv
module sir_bof_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic       start_req = 1'b0;
  logic [5:0] flag_count = 6'd0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sir_bof_seq u_sir_bof_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .start_req(start_req), .flag_count(flag_count), .out_ready(out_ready),
    .out_valid(out_valid), .out_byte(out_byte), .done(done)
  );

  // vectors: count, select, stall, expected length, expected leading byte
  localparam int NV = 8;
  localparam int         V_CNT  [NV] = '{1, 0, 2, 2, 5, 63, 3, 4};
  localparam bit         V_SEL  [NV] = '{0, 0, 0, 1, 0, 1, 1, 0};
  localparam bit         V_STL  [NV] = '{0, 1, 0, 1, 1, 0, 1, 0};
  localparam int         V_LEN  [NV] = '{1, 1, 2, 2, 5, 63, 3, 4};
  localparam logic [7:0] V_LEAD [NV] = '{8'hC0, 8'hC0, 8'hFF, 8'hC0,
                                         8'hFF, 8'hC0, 8'hC0, 8'hFF};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int cnt, input bit sel, input bit do_cfg,
                         input bit stall, input int exp_len,
                         input logic [7:0] lead, input bit perturb);
    logic [7:0] got [0:127];
    int  n = 0;
    int  cyc = 0;
    bit  got_done = 1'b0;
    int  bad = 0;
    bit  hs;
    logic [7:0] b;
    if (do_cfg) begin
      @(negedge clk); cfg_we = 1'b1; cfg_sel = sel;
      @(negedge clk); cfg_we = 1'b0;
    end
    start_req = 1'b1; flag_count = 6'(cnt);
    @(negedge clk);
    start_req = 1'b0;
    check(out_valid == 1'b1, "R10 valid after start", int'(out_valid), 1);
    while (!got_done && cyc < 200) begin
      out_ready = stall ? (cyc % 2 == 1) : 1'b1;
      if (perturb && cyc == 1) begin
        cfg_we = 1'b1; cfg_sel = ~sel; flag_count = 6'(cnt + 5); start_req = 1'b1;
      end else if (perturb && cyc == 2) begin
        cfg_we = 1'b0; start_req = 1'b0;
      end
      hs = out_valid && out_ready;
      b  = out_byte;
      if (hs) begin got[n] = b; n++; end
      @(negedge clk);
      cyc++;
      if (!hs && !done)
        check(out_valid && out_byte == b, "R7 stall holds byte", int'(out_byte), int'(b));
      if (done) begin
        got_done = 1'b1;
        check(!out_valid, "R8 valid low with done", int'(out_valid), 0);
      end
    end
    out_ready = 1'b0; start_req = 1'b0; cfg_we = 1'b0;
    check(got_done, "R8 done seen", int'(got_done), 1);
    check(n == exp_len, "R2 flag count", n, exp_len);
    for (int i = 0; i < n && i < 128; i++) begin
      if (got[i] != ((i == exp_len - 1) ? 8'hC0 : lead)) bad++;
    end
    check(bad == 0 && n > 0 && got[n-1] == 8'hC0, "R1 R2 R3 byte values", bad, 0);
    @(negedge clk);
    check(!done && !out_valid, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!out_valid && !done, "R10 reset outputs", int'({out_valid, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    // R4 select defaults to 1: three flags all 0xC0
    run_seq(3, 1'b0, 1'b0, 1'b0, 3, 8'hC0, 1'b0);
    // table: R1, R5, R2, R3, R7
    for (int k = 0; k < NV; k++)
      run_seq(V_CNT[k], V_SEL[k], 1'b1, V_STL[k], V_LEN[k], V_LEAD[k], 1'b0);
    // R6 and R9: mid-sequence config, count and start changes
    run_seq(4, 1'b0, 1'b1, 1'b0, 4, 8'hFF, 1'b0);
    run_seq(4, 1'b0, 1'b1, 1'b1, 4, 8'hFF, 1'b1);
    repeat (3) begin
      @(negedge clk);
      check(!out_valid && !done, "R9 no queued start", int'(out_valid), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule